// File: doc/BRIEF.md
# Lane Shift Unit with Automatic FIFO Transfer

This block holds the two shift registers of one lane of a programmable I/O sequencer. The capture register collects bit groups delivered by IN operations and hands a full word to a receive FIFO. The emit register holds a word taken from a transmit FIFO and releases bit groups for OUT operations. Each register has its own shift direction. A threshold, counted in bits, can trigger a transfer to or from the FIFO automatically.

A sequencer issues one operation per cycle on the operation port: a kind, a bit count and, for IN, the data. A FIFO transfer completes in the same cycle as the operation through valid/ready handshakes. When the FIFO cannot take or supply a word, the block raises a stall flag, keeps its state, and leaves the sequencer to retry. Instruction decode and pin mapping sit outside this block.

Top module: `lane_shifter`

## Requirements
- R1: After reset both registers hold zero, the capture count is zero and the emit register counts as fully shifted out (32). `out_valid`, `op_stall` and `rx_valid` are low. A PUSH delivers 0, and an OUT without autopull yields 0.
- R2: With `cfg_in_right`=0 (left), an IN of n bits computes `isr = (isr << n) | din[n-1:0]`, so new bits enter at the least-significant end.
- R3: With `cfg_in_right`=1 (right), an IN of n bits shifts the register right by n and places `din[n-1:0]` in its n most-significant bits.
- R4: With `cfg_out_right`=0 (left), an OUT of n bits takes the n most-significant bits of the register and shifts it left by n. The cycle after acceptance, `out_valid` is 1 and `out_bits` holds those bits right-justified.
- R5: With `cfg_out_right`=1 (right), an OUT of n bits takes the n least-significant bits and shifts the register right by n.
- R6: With `cfg_autopush`=1, when an IN brings the capture count to at least the push threshold, the shifted word appears on `rx_data` with `rx_valid` in the same cycle. The register and its count then clear to zero.
- R7: With `cfg_autopull`=1, an OUT that finds the emitted count at or above the pull threshold first loads `tx_data` (with `tx_ready` high in that cycle) and resets the count to zero. It then shifts from the new word. Below the threshold, no pull occurs.
- R8: A bit count or threshold field of 0 means 32. A 32-bit IN or OUT moves a whole word in one operation.
- R9: An operation blocked by a full receive FIFO or an empty transmit FIFO raises `op_stall` in that cycle. It changes no state and produces no `out_valid`. It completes once the FIFO is able to transfer.
- R10: `op_kind` encodes IN=0, OUT=1, PUSH=2, PULL=3. PUSH sends the capture register to the receive FIFO and clears it. PULL loads the emit register from the transmit FIFO and resets its count to 0.
- R11: With `cfg_autopush`=0, an IN never raises `rx_valid`, whatever the count. With no operation, neither FIFO port transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_right | input | 1 | Capture shift direction, 0 left, 1 right |
| cfg_out_right | input | 1 | Emit shift direction, 0 left, 1 right |
| cfg_autopush | input | 1 | Enable automatic push |
| cfg_autopull | input | 1 | Enable automatic pull |
| cfg_push_thr | input | 5 | Push threshold in bits, 0 means 32 |
| cfg_pull_thr | input | 5 | Pull threshold in bits, 0 means 32 |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 IN, 1 OUT, 2 PUSH, 3 PULL |
| op_bits | input | 5 | Bit count, 0 means 32 |
| op_din | input | 32 | Data bits for IN |
| op_stall | output | 1 | Operation blocked this cycle |
| out_valid | output | 1 | Registered: OUT result present |
| out_bits | output | 32 | Registered OUT bits, right-justified |
| rx_valid | output | 1 | Word offered to receive FIFO |
| rx_data | output | 32 | Word for receive FIFO |
| rx_ready | input | 1 | Receive FIFO accepts |
| tx_valid | input | 1 | Transmit FIFO has a word |
| tx_data | input | 32 | Word from transmit FIFO |
| tx_ready | output | 1 | Word taken from transmit FIFO |

## Verification
The handshakes and the stall flag are combinational results of the current operation. The bench reads them 1 ns after driving the operation on the falling edge, before the capturing rising edge. The OUT result is registered and is due one cycle after acceptance, so the bench reads `out_bits` and `out_valid` 1 ns after that rising edge. The capture register's content is observed only through a later PUSH or autopush. A stalled attempt is repeated to show that the offered word did not change.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    OP_IN   = 2'd0,
    OP_OUT  = 2'd1,
    OP_PUSH = 2'd2,
    OP_PULL = 2'd3
  } lane_op_e;
endpackage

// File: rtl/lane_isr.sv
module lane_isr #(
  parameter int W  = 32,
  parameter int TW = $clog2(W),
  parameter int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_right,
  input  logic          autopush,
  input  logic [TW-1:0] thr,
  input  logic          do_in,
  input  logic          do_push,
  input  logic [TW-1:0] nbits,
  input  logic [W-1:0]  din,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [W-1:0]  rx_data,
  output logic          stall
);
  localparam logic [CW-1:0] WC = CW'(W);

  logic [W-1:0]  isr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] n_eff, thr_eff, cnt_next;
  logic [CW:0]   sum;
  logic [W-1:0]  mask, fresh, shifted;
  logic          trig;

  always_comb begin
    n_eff    = (nbits == '0) ? WC : {1'b0, nbits};
    thr_eff  = (thr == '0) ? WC : {1'b0, thr};
    mask     = {W{1'b1}} >> (WC - n_eff);
    fresh    = din & mask;
    if (dir_right) shifted = (isr_q >> n_eff) | (fresh << (WC - n_eff));
    else           shifted = (isr_q << n_eff) | fresh;
    sum      = {1'b0, cnt_q} + {1'b0, n_eff};
    cnt_next = (sum > {1'b0, WC}) ? WC : sum[CW-1:0];
    trig     = autopush && (cnt_next >= thr_eff);
    rx_valid = (do_in && trig) || do_push;
    rx_data  = do_push ? isr_q : shifted;
    stall    = rx_valid && !rx_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      cnt_q <= '0;
    end else if (do_in && !stall) begin
      if (trig) begin
        isr_q <= '0;
        cnt_q <= '0;
      end else begin
        isr_q <= shifted;
        cnt_q <= cnt_next;
      end
    end else if (do_push && rx_ready) begin
      isr_q <= '0;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/lane_osr.sv
module lane_osr #(
  parameter int W  = 32,
  parameter int TW = $clog2(W),
  parameter int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_right,
  input  logic          autopull,
  input  logic [TW-1:0] thr,
  input  logic          do_out,
  input  logic          do_pull,
  input  logic [TW-1:0] nbits,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_data,
  output logic          tx_ready,
  output logic          stall,
  output logic          out_valid,
  output logic [W-1:0]  out_bits
);
  localparam logic [CW-1:0] WC = CW'(W);

  logic [W-1:0]  osr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] n_eff, thr_eff, src_cnt, cnt_next;
  logic [CW:0]   sum;
  logic [W-1:0]  mask, src, bits, rest;
  logic          need_pull, want_word;

  always_comb begin
    n_eff     = (nbits == '0) ? WC : {1'b0, nbits};
    thr_eff   = (thr == '0) ? WC : {1'b0, thr};
    need_pull = do_out && autopull && (cnt_q >= thr_eff);
    src       = need_pull ? tx_data : osr_q;
    src_cnt   = need_pull ? '0 : cnt_q;
    mask      = {W{1'b1}} >> (WC - n_eff);
    if (dir_right) begin
      bits = src & mask;
      rest = src >> n_eff;
    end else begin
      bits = src >> (WC - n_eff);
      rest = src << n_eff;
    end
    sum       = {1'b0, src_cnt} + {1'b0, n_eff};
    cnt_next  = (sum > {1'b0, WC}) ? WC : sum[CW-1:0];
    want_word = need_pull || do_pull;
    tx_ready  = want_word && tx_valid;
    stall     = want_word && !tx_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osr_q     <= '0;
      cnt_q     <= WC;
      out_valid <= 1'b0;
      out_bits  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (do_out && !stall) begin
        osr_q     <= rest;
        cnt_q     <= cnt_next;
        out_bits  <= bits;
        out_valid <= 1'b1;
      end else if (do_pull && tx_valid) begin
        osr_q <= tx_data;
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
  parameter int W  = 32,
  parameter int TW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_in_right,
  input  logic          cfg_out_right,
  input  logic          cfg_autopush,
  input  logic          cfg_autopull,
  input  logic [TW-1:0] cfg_push_thr,
  input  logic [TW-1:0] cfg_pull_thr,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [TW-1:0] op_bits,
  input  logic [W-1:0]  op_din,
  output logic          op_stall,
  output logic          out_valid,
  output logic [W-1:0]  out_bits,
  output logic          rx_valid,
  output logic [W-1:0]  rx_data,
  input  logic          rx_ready,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_data,
  output logic          tx_ready
);
  import lane_pkg::*;

  lane_op_e kind;
  logic do_in, do_out, do_push, do_pull;
  logic in_stall, out_stall;

  always_comb begin
    kind    = lane_op_e'(op_kind);
    do_in   = op_valid && (kind == OP_IN);
    do_out  = op_valid && (kind == OP_OUT);
    do_push = op_valid && (kind == OP_PUSH);
    do_pull = op_valid && (kind == OP_PULL);
  end

  lane_isr #(.W(W), .TW(TW)) u_isr (
    .clk(clk), .rst(rst), .dir_right(cfg_in_right), .autopush(cfg_autopush),
    .thr(cfg_push_thr), .do_in(do_in), .do_push(do_push), .nbits(op_bits),
    .din(op_din), .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .stall(in_stall)
  );

  lane_osr #(.W(W), .TW(TW)) u_osr (
    .clk(clk), .rst(rst), .dir_right(cfg_out_right), .autopull(cfg_autopull),
    .thr(cfg_pull_thr), .do_out(do_out), .do_pull(do_pull), .nbits(op_bits),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .stall(out_stall), .out_valid(out_valid), .out_bits(out_bits)
  );

  assign op_stall = in_stall || out_stall;
endmodule

// File: rtl/lane_shifter_chk.sv
module lane_shifter_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       op_stall,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       out_valid
);
  assert_push_block_stalls_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |-> op_stall);

  assert_pull_takes_word_R7: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> (tx_valid && !op_stall));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (!rx_valid && !tx_ready && !op_stall));

  assert_out_result_due_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd1 && !op_stall) |=> out_valid);

  assert_out_result_cause_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(op_valid && op_kind == 2'd1 && !op_stall));

  assert_stall_no_result_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_kind == 2'd1 && op_stall) |=> !out_valid);
endmodule

bind lane_shifter lane_shifter_chk u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
  .op_stall(op_stall), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .out_valid(out_valid)
);

// File: tb/sim_lane_shifter.sv
`timescale 1ns/1ps
module sim_lane_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_in_right = 0, cfg_out_right = 0, cfg_autopush = 0, cfg_autopull = 0;
  logic [4:0]  cfg_push_thr = 0, cfg_pull_thr = 0;
  logic        op_valid = 0;
  logic [1:0]  op_kind = 0;
  logic [4:0]  op_bits = 0;
  logic [31:0] op_din = 0;
  logic        op_stall, out_valid, rx_valid, tx_ready;
  logic [31:0] out_bits, rx_data;
  logic        rx_ready = 1, tx_valid = 0;
  logic [31:0] tx_data = 0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic        s_stall, s_rxv, s_txr, s_ov;
  logic [31:0] s_rxd, s_ob;

  always #2.5 clk = ~clk;

  lane_shifter u0 (
    .clk(clk), .rst(rst), .cfg_in_right(cfg_in_right), .cfg_out_right(cfg_out_right),
    .cfg_autopush(cfg_autopush), .cfg_autopull(cfg_autopull),
    .cfg_push_thr(cfg_push_thr), .cfg_pull_thr(cfg_pull_thr),
    .op_valid(op_valid), .op_kind(op_kind), .op_bits(op_bits), .op_din(op_din),
    .op_stall(op_stall), .out_valid(out_valid), .out_bits(out_bits),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] k, input logic [4:0] n, input logic [31:0] d);
    @(negedge clk);
    op_valid = 1; op_kind = k; op_bits = n; op_din = d;
    #1;
    s_stall = op_stall; s_rxv = rx_valid; s_rxd = rx_data; s_txr = tx_ready;
    @(posedge clk);
    #1;
    s_ov = out_valid; s_ob = out_bits;
    op_valid = 0;
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 out_valid", {31'd0, out_valid}, 0);
    chk("R1 op_stall", {31'd0, op_stall}, 0);
    chk("R1 rx_valid", {31'd0, rx_valid}, 0);
    op(2'd2, 0, 0);
    chk("R1 push empty", s_rxd, 32'h0);
    op(2'd1, 8, 0);
    chk("R1 out empty", s_ob, 32'h0);
  endtask

  task automatic t_in_left;
    cfg_in_right = 0; cfg_autopush = 0;
    op(2'd0, 4, 32'hA);
    chk("R11 no autopush", {31'd0, s_rxv}, 0);
    op(2'd0, 8, 32'hFFFF_FF5C);
    chk("R11 no autopush", {31'd0, s_rxv}, 0);
    op(2'd2, 0, 0);
    chk("R2 left capture", s_rxd, 32'h0000_0A5C);
    chk("R10 push valid", {31'd0, s_rxv}, 1);
  endtask

  task automatic t_in_right;
    cfg_in_right = 1;
    op(2'd0, 4, 32'hA);
    op(2'd0, 4, 32'h3);
    op(2'd2, 0, 0);
    chk("R3 right capture", s_rxd, 32'h3A00_0000);
    cfg_in_right = 0;
  endtask

  task automatic t_out_left;
    cfg_out_right = 0; tx_valid = 1; tx_data = 32'h1234_5678;
    op(2'd3, 0, 0);
    chk("R10 pull ready", {31'd0, s_txr}, 1);
    tx_valid = 0;
    op(2'd1, 8, 0);
    chk("R4 out_valid", {31'd0, s_ov}, 1);
    chk("R4 left 8", s_ob, 32'h12);
    op(2'd1, 4, 0);
    chk("R4 left 4", s_ob, 32'h3);
  endtask

  task automatic t_out_right;
    cfg_out_right = 1; tx_valid = 1; tx_data = 32'h1234_5678;
    op(2'd3, 0, 0);
    tx_valid = 0;
    op(2'd1, 8, 0);
    chk("R5 right 8", s_ob, 32'h78);
    op(2'd1, 4, 0);
    chk("R5 right 4", s_ob, 32'h6);
    cfg_out_right = 0;
  endtask

  task automatic t_autopush;
    cfg_autopush = 1; cfg_push_thr = 8; rx_ready = 1;
    op(2'd0, 4, 32'h1);
    chk("R6 below thr", {31'd0, s_rxv}, 0);
    op(2'd0, 4, 32'h2);
    chk("R6 push valid", {31'd0, s_rxv}, 1);
    chk("R6 push word", s_rxd, 32'h12);
    op(2'd2, 0, 0);
    chk("R6 cleared", s_rxd, 32'h0);
  endtask

  task automatic t_full32;
    cfg_autopush = 1; cfg_push_thr = 0;
    op(2'd0, 16, 32'h1234);
    chk("R8 16 of 32", {31'd0, s_rxv}, 0);
    op(2'd0, 16, 32'h5678);
    chk("R8 thr 32 word", s_rxd, 32'h1234_5678);
    op(2'd0, 0, 32'hDEAD_BEEF);
    chk("R8 in 32 valid", {31'd0, s_rxv}, 1);
    chk("R8 in 32 word", s_rxd, 32'hDEAD_BEEF);
    cfg_autopush = 0;
    tx_valid = 1; tx_data = 32'hCAFE_F00D;
    op(2'd3, 0, 0);
    tx_valid = 0;
    op(2'd1, 0, 0);
    chk("R8 out 32", s_ob, 32'hCAFE_F00D);
  endtask

  task automatic t_autopull;
    cfg_autopull = 1; cfg_pull_thr = 8; tx_valid = 1; tx_data = 32'hAABB_CCDD;
    op(2'd3, 0, 0);
    tx_data = 32'hF500_0000;
    op(2'd1, 8, 0);
    chk("R7 no pull below", {31'd0, s_txr}, 0);
    chk("R7 first byte", s_ob, 32'hAA);
    op(2'd1, 4, 0);
    chk("R7 pull taken", {31'd0, s_txr}, 1);
    chk("R7 new word", s_ob, 32'hF);
    op(2'd1, 4, 0);
    chk("R7 count reset", {31'd0, s_txr}, 0);
    chk("R7 next nibble", s_ob, 32'h5);
    tx_valid = 0;
  endtask

  task automatic t_stall;
    cfg_autopush = 1; cfg_push_thr = 8; rx_ready = 1;
    op(2'd0, 4, 32'h5);
    rx_ready = 0;
    op(2'd0, 4, 32'hA);
    chk("R9 rx stall", {31'd0, s_stall}, 1);
    chk("R9 rx offered", s_rxd, 32'h5A);
    op(2'd0, 4, 32'hA);
    chk("R9 rx held", s_rxd, 32'h5A);
    rx_ready = 1;
    op(2'd0, 4, 32'hA);
    chk("R9 rx go", {31'd0, s_stall}, 0);
    chk("R9 rx word", s_rxd, 32'h5A);
    cfg_autopush = 0;
    cfg_autopull = 1; cfg_pull_thr = 8; tx_valid = 1; tx_data = 32'h1122_3344;
    op(2'd3, 0, 0);
    tx_valid = 0;
    op(2'd1, 0, 0);
    chk("R9 drain", s_ob, 32'h1122_3344);
    op(2'd1, 8, 0);
    chk("R9 tx stall", {31'd0, s_stall}, 1);
    chk("R9 no result", {31'd0, s_ov}, 0);
    tx_valid = 1; tx_data = 32'h9988_7766;
    op(2'd1, 8, 0);
    chk("R9 tx go", {31'd0, s_stall}, 0);
    chk("R9 tx word", s_ob, 32'h99);
    tx_valid = 0;
    op(2'd3, 0, 0);
    chk("R9 pull empty", {31'd0, s_stall}, 1);
    cfg_autopull = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_in_left();
    t_in_right();
    t_out_left();
    t_out_right();
    t_autopush();
    t_full32();
    t_autopull();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule